// File: doc/BRIEF.md
# Banked TLB Special-Register Port

This block sits beside a processor core that manages its translation buffers in software. The core moves values into and out of a small file of support registers. A two-bit bank register picks which bank of that file the moves address. Two of the banks belong to the two memory-management units, one bank for each. Each unit owns a translation store of 4 sets by 16 ways. Every entry in a store is a pair of 32-bit words, an upper tag word and a lower attribute word.

In those two banks, register moves also reach the translation store. A move into register 6 sets register 6 and also the unit's cause register, register 7. A move into register 5 writes one whole entry. The slot is chosen by the selector in register 4. The new entry takes its lower word from the moved value and its upper word from the cause register. If the entry being replaced was valid, the block sends out a one-cycle page-invalidate pulse carrying the old page's virtual address. Every read in those banks first copies the selected entry into registers 6 and 5 and then returns the addressed register.

A separate compare path handles process-ID flush requests. It checks the low 8 bits of a requested ID against the current ID. It signals a flush of the current ID only when the two differ.

Top module: `tlb_sreg_port`

## Requirements
- R1: After reset, every output is zero, every support register holds zero, and every translation entry reads as zero, so no entry is valid.
- R2: The bank register keeps only bits [1:0] of the value written to it. Writing 0xFFFF_FFF5, for example, selects bank 1.
- R3: A register write stores the value into the addressed register (0 to 15) of the active bank. In banks 0 and 3 a later read returns that value unchanged.
- R4: In bank 1 or 2, a write to register 6 also stores the same value into register 7. In banks 0 and 3, register 7 is left as it was.
- R5: In bank 1 or 2, a write to register 5 replaces the entry at set = register 4 bits [5:4] and way = register 4 bits [3:0]. The new lower word is the written value and the new upper word is register 7.
- R6: In bank 1 or 2, a read of any register first loads register 6 with the selected entry's upper word and register 5 with its lower word. The read then returns the addressed register, including those fresh values.
- R7: Bank 1 uses the first unit's store and bank 2 uses the second. The same slot in the two stores holds independent entries.
- R8: When an entry is replaced and its old lower word has bit 3 set, inval_valid pulses for exactly one cycle. inval_vaddr then holds old upper word bits [31:13] followed by 13 zero bits. Replacing an entry whose bit 3 is clear, or a never-filled entry, gives no pulse.
- R9: A read gives rd_valid and rd_data one cycle later. If a read and a write are requested in the same cycle, only the write is performed and rd_valid stays low.
- R10: A flush request compares bits [7:0] of the requested ID with bits [7:0] of the current ID. Only when they differ, pid_flush_o pulses one cycle later with pid_flush_id set to the current ID's low 8 bits.
- R11: In banks 0 and 3, writes to registers 5 and 6 have no effect on the translation stores and never raise an invalidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bsel_we | input | 1 | Write the bank register |
| bsel_wdata | input | 32 | Bank register value (bits [1:0] kept) |
| sr_wr | input | 1 | Move into a support register |
| sr_rd | input | 1 | Move out of a support register |
| sr_addr | input | 4 | Support register number |
| sr_wdata | input | 32 | Value moved into the register |
| rd_valid | output | 1 | Read result valid |
| rd_data | output | 32 | Read result |
| pid_flush_req | input | 1 | Process-ID flush request |
| pid_flush_val | input | 32 | Requested process ID |
| pid_current | input | 32 | Current process ID |
| pid_flush_o | output | 1 | Flush-current-ID pulse |
| pid_flush_id | output | 8 | ID to flush |
| inval_valid | output | 1 | Page-invalidate pulse |
| inval_vaddr | output | 32 | Virtual address to invalidate |

## Verification
Every result is registered exactly once. Read data, the invalidate pulse and the flush pulse are therefore all due in the cycle after the request is sampled. Register and store updates become visible to a request issued in the very next cycle. The bench drives one request per cycle on the falling edge and pushes that cycle's expected outputs into a queue. A monitor wakes a quarter period after each rising edge and compares the oldest queued item against the outputs. This keeps every expectation aligned to the single register stage, including back-to-back replacements and a read issued straight after a write.

// File: rtl/tlb_sreg_pkg.sv
package tlb_sreg_pkg;
  localparam int XLEN       = 32;
  localparam int NBANK      = 4;
  localparam int NREG       = 16;
  localparam int NMMU       = 2;
  localparam int NSET       = 4;
  localparam int NIDX       = 16;
  localparam int PAGE_BITS  = 13;
  localparam int PID_BITS   = 8;
  localparam int VALID_BIT  = 3;
  // Register numbers whose meaning the control logic decodes
  localparam int REG_SEL    = 4;
  localparam int REG_LO     = 5;
  localparam int REG_HI     = 6;
  localparam int REG_CAUSE  = 7;
endpackage

// File: rtl/tlb_bank_file.sv
module tlb_bank_file
  import tlb_sreg_pkg::*;
#(
  parameter int DW     = XLEN,
  parameter int BANKS  = NBANK,
  parameter int REGS   = NREG,
  parameter int BANK_W = $clog2(BANKS),
  parameter int REG_W  = $clog2(REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] bank,
  input  logic              wr_en,
  input  logic [REG_W-1:0]  wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              dup_en,
  input  logic              mir_en,
  input  logic [DW-1:0]     mir_hi,
  input  logic [DW-1:0]     mir_lo,
  input  logic [REG_W-1:0]  rd_addr,
  output logic [DW-1:0]     rd_word,
  output logic [DW-1:0]     sel_word,
  output logic [DW-1:0]     cause_word
);
  logic [DW-1:0] regs [BANKS][REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int b = 0; b < BANKS; b++)
        for (int r = 0; r < REGS; r++)
          regs[b][r] <= '0;
    end else begin
      if (mir_en) begin
        regs[bank][REG_HI] <= mir_hi;
        regs[bank][REG_LO] <= mir_lo;
      end
      if (wr_en) begin
        regs[bank][wr_addr] <= wr_data;
        if (dup_en) regs[bank][REG_CAUSE] <= wr_data;
      end
    end
  end

  assign rd_word    = regs[bank][rd_addr];
  assign sel_word   = regs[bank][REG_SEL];
  assign cause_word = regs[bank][REG_CAUSE];

  AST_HI_COPIES_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $past(wr_en && dup_en) |-> regs[$past(bank)][REG_CAUSE] == $past(wr_data)); // R4
  AST_MIRROR_LOADED: assert property (@(posedge clk) disable iff (rst)
    $past(mir_en && !wr_en) |-> (regs[$past(bank)][REG_LO] == $past(mir_lo)
                                 && regs[$past(bank)][REG_HI] == $past(mir_hi))); // R6
endmodule

// File: rtl/tlb_entry_ram.sv
module tlb_entry_ram
  import tlb_sreg_pkg::*;
#(
  parameter int DW     = XLEN,
  parameter int UNITS  = NMMU,
  parameter int SETS   = NSET,
  parameter int WAYS   = NIDX,
  parameter int MMU_W  = (UNITS > 1) ? $clog2(UNITS) : 1,
  parameter int SLOT_W = $clog2(SETS) + $clog2(WAYS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MMU_W-1:0]  lk_mmu,
  input  logic [SLOT_W-1:0] lk_slot,
  output logic [DW-1:0]     lk_hi,
  output logic [DW-1:0]     lk_lo,
  input  logic              we,
  input  logic [MMU_W-1:0]  w_mmu,
  input  logic [SLOT_W-1:0] w_slot,
  input  logic [DW-1:0]     w_hi,
  input  logic [DW-1:0]     w_lo
);
  localparam int AW    = MMU_W + SLOT_W;
  localparam int DEPTH = 1 << AW;

  logic [2*DW-1:0] mem [DEPTH];
  logic [DEPTH-1:0] filled;
  logic [AW-1:0] raddr, waddr;
  logic [2*DW-1:0] rword;

  assign raddr = {lk_mmu, lk_slot};
  assign waddr = {w_mmu, w_slot};

  // Storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= {w_hi, w_lo};
  end

  always_ff @(posedge clk) begin
    if (rst)     filled <= '0;
    else if (we) filled[waddr] <= 1'b1;
  end

  assign rword = mem[raddr];
  assign lk_hi = filled[raddr] ? rword[2*DW-1:DW] : '0;
  assign lk_lo = filled[raddr] ? rword[DW-1:0]    : '0;

  AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (rst)
    ($past(we) && raddr == $past(waddr)) |-> (lk_hi == $past(w_hi) && lk_lo == $past(w_lo))); // R5
endmodule

// File: rtl/pid_flush_cmp.sv
module pid_flush_cmp
  import tlb_sreg_pkg::*;
#(
  parameter int DW    = XLEN,
  parameter int PID_W = PID_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req,
  input  logic [DW-1:0]    pid_req,
  input  logic [DW-1:0]    pid_cur,
  output logic             flush_o,
  output logic [PID_W-1:0] flush_pid_o
);
  logic differ;
  logic unused_pid_hi;

  assign differ        = pid_req[PID_W-1:0] != pid_cur[PID_W-1:0];
  assign unused_pid_hi = ^{pid_req[DW-1:PID_W], pid_cur[DW-1:PID_W]};

  always_ff @(posedge clk) begin
    if (rst) begin
      flush_o     <= 1'b0;
      flush_pid_o <= '0;
    end else begin
      flush_o <= req && differ;
      if (req && differ) flush_pid_o <= pid_cur[PID_W-1:0];
    end
  end

  AST_FLUSH_ONLY_ON_DIFF: assert property (@(posedge clk) disable iff (rst)
    flush_o |-> ($past(req) && $past(pid_req[PID_W-1:0]) != $past(pid_cur[PID_W-1:0]))); // R10
endmodule

// File: rtl/tlb_sreg_port.sv
module tlb_sreg_port
  import tlb_sreg_pkg::*;
#(
  parameter int DW     = XLEN,
  parameter int BANKS  = NBANK,
  parameter int REGS   = NREG,
  parameter int UNITS  = NMMU,
  parameter int SETS   = NSET,
  parameter int WAYS   = NIDX,
  parameter int PG_W   = PAGE_BITS,
  parameter int PID_W  = PID_BITS,
  parameter int BANK_W = $clog2(BANKS),
  parameter int REG_W  = $clog2(REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bsel_we,
  input  logic [DW-1:0]    bsel_wdata,
  input  logic             sr_wr,
  input  logic             sr_rd,
  input  logic [REG_W-1:0] sr_addr,
  input  logic [DW-1:0]    sr_wdata,
  output logic             rd_valid,
  output logic [DW-1:0]    rd_data,
  input  logic             pid_flush_req,
  input  logic [DW-1:0]    pid_flush_val,
  input  logic [DW-1:0]    pid_current,
  output logic             pid_flush_o,
  output logic [PID_W-1:0] pid_flush_id,
  output logic             inval_valid,
  output logic [DW-1:0]    inval_vaddr
);
  localparam int MMU_W  = (UNITS > 1) ? $clog2(UNITS) : 1;
  localparam int SLOT_W = $clog2(SETS) + $clog2(WAYS);

  logic [BANK_W-1:0] bank_q, bank_m1;
  logic              tlb_act, do_rd, commit, dup, mirror;
  logic [DW-1:0]     rd_word, sel_word, cause_word, lk_hi, lk_lo, rd_val;
  logic [MMU_W-1:0]  mmu;
  logic [SLOT_W-1:0] slot;
  logic              unused_top;

  always_ff @(posedge clk) begin
    if (rst)          bank_q <= '0;
    else if (bsel_we) bank_q <= bsel_wdata[BANK_W-1:0];
  end

  assign tlb_act = (bank_q != '0) && (int'(bank_q) <= UNITS);
  assign bank_m1 = bank_q - 1'b1;
  assign mmu     = bank_m1[MMU_W-1:0];
  assign slot    = sel_word[SLOT_W-1:0];
  assign do_rd   = sr_rd && !sr_wr;
  assign commit  = sr_wr && tlb_act && (sr_addr == REG_W'(REG_LO));
  assign dup     = sr_wr && tlb_act && (sr_addr == REG_W'(REG_HI));
  assign mirror  = do_rd && tlb_act;
  assign unused_top = ^{bsel_wdata[DW-1:BANK_W], sel_word[DW-1:SLOT_W], bank_m1};

  tlb_bank_file #(.DW(DW), .BANKS(BANKS), .REGS(REGS), .BANK_W(BANK_W), .REG_W(REG_W)) u_banks (
    .clk(clk), .rst(rst), .bank(bank_q),
    .wr_en(sr_wr), .wr_addr(sr_addr), .wr_data(sr_wdata), .dup_en(dup),
    .mir_en(mirror), .mir_hi(lk_hi), .mir_lo(lk_lo),
    .rd_addr(sr_addr), .rd_word(rd_word), .sel_word(sel_word), .cause_word(cause_word)
  );

  tlb_entry_ram #(.DW(DW), .UNITS(UNITS), .SETS(SETS), .WAYS(WAYS),
                  .MMU_W(MMU_W), .SLOT_W(SLOT_W)) u_store (
    .clk(clk), .rst(rst),
    .lk_mmu(mmu), .lk_slot(slot), .lk_hi(lk_hi), .lk_lo(lk_lo),
    .we(commit), .w_mmu(mmu), .w_slot(slot), .w_hi(cause_word), .w_lo(sr_wdata)
  );

  pid_flush_cmp #(.DW(DW), .PID_W(PID_W)) u_pid (
    .clk(clk), .rst(rst), .req(pid_flush_req), .pid_req(pid_flush_val),
    .pid_cur(pid_current), .flush_o(pid_flush_o), .flush_pid_o(pid_flush_id)
  );

  always_comb begin
    rd_val = rd_word;
    if (tlb_act && sr_addr == REG_W'(REG_LO)) rd_val = lk_lo;
    if (tlb_act && sr_addr == REG_W'(REG_HI)) rd_val = lk_hi;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid    <= 1'b0;
      rd_data     <= '0;
      inval_valid <= 1'b0;
      inval_vaddr <= '0;
    end else begin
      rd_valid <= do_rd;
      if (do_rd) rd_data <= rd_val;
      inval_valid <= commit && lk_lo[VALID_BIT];
      if (commit && lk_lo[VALID_BIT])
        inval_vaddr <= {lk_hi[DW-1:PG_W], {PG_W{1'b0}}};
    end
  end

  AST_INVAL_FROM_COMMIT: assert property (@(posedge clk) disable iff (rst)
    inval_valid |-> $past(sr_wr && sr_addr == REG_W'(REG_LO))); // R8
  AST_INVAL_TLB_BANK_ONLY: assert property (@(posedge clk) disable iff (rst)
    inval_valid |-> ($past(bank_q) != '0 && int'($past(bank_q)) <= UNITS)); // R11
  AST_RD_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(sr_rd && !sr_wr)); // R9
endmodule

// File: tb/tb_tlb_sreg_port.sv
module tb_tlb_sreg_port;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bsel_we = 1'b0, sr_wr = 1'b0, sr_rd = 1'b0, pid_flush_req = 1'b0;
  logic [31:0] bsel_wdata = '0, sr_wdata = '0, pid_flush_val = '0, pid_current = '0;
  logic [3:0]  sr_addr = '0;
  logic        rd_valid, pid_flush_o, inval_valid;
  logic [31:0] rd_data, inval_vaddr;
  logic [7:0]  pid_flush_id;

  tlb_sreg_port dut (
    .clk(clk), .rst(rst), .bsel_we(bsel_we), .bsel_wdata(bsel_wdata),
    .sr_wr(sr_wr), .sr_rd(sr_rd), .sr_addr(sr_addr), .sr_wdata(sr_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .pid_flush_req(pid_flush_req), .pid_flush_val(pid_flush_val), .pid_current(pid_current),
    .pid_flush_o(pid_flush_o), .pid_flush_id(pid_flush_id),
    .inval_valid(inval_valid), .inval_vaddr(inval_vaddr)
  );

  always #10 clk = ~clk;

  typedef struct packed {
    logic        rv; logic [31:0] rd;
    logic        iv; logic [31:0] ia;
    logic        fv; logic [7:0]  fp;
  } exp_t;

  exp_t  q[$];
  string tq[$];
  int    checks = 0, errors = 0;
  bit    done = 1'b0;

  // Bench model of support registers and the two stores
  logic [31:0] bm [4][16];
  logic [31:0] th [2][64];
  logic [31:0] tl [2][64];
  bit          tf [2][64];
  int          bank = 0;

  task automatic step(input bit wr, input bit rd, input logic [3:0] a, input logic [31:0] d,
                      input bit bw, input logic [31:0] bd,
                      input bit fr, input logic [31:0] fp, input logic [31:0] cp,
                      input string tag);
    exp_t e;
    bit   tb;
    int   m, s;
    @(negedge clk);
    sr_wr = wr; sr_rd = rd; sr_addr = a; sr_wdata = d;
    bsel_we = bw; bsel_wdata = bd;
    pid_flush_req = fr; pid_flush_val = fp; pid_current = cp;
    e = '0;
    tb = (bank == 1 || bank == 2);
    m = bank - 1;
    s = int'(bm[bank][4][5:0]);
    if (wr) begin
      if (tb && a == 4'd5) begin
        if (tf[m][s] && tl[m][s][3]) begin
          e.iv = 1'b1;
          e.ia = {th[m][s][31:13], 13'b0};
        end
        th[m][s] = bm[bank][7];
        tl[m][s] = d;
        tf[m][s] = 1'b1;
      end
      bm[bank][a] = d;
      if (tb && a == 4'd6) bm[bank][7] = d;
    end else if (rd) begin
      if (tb) begin
        bm[bank][6] = tf[m][s] ? th[m][s] : 32'h0;
        bm[bank][5] = tf[m][s] ? tl[m][s] : 32'h0;
      end
      e.rv = 1'b1;
      e.rd = bm[bank][a];
    end
    if (fr && fp[7:0] != cp[7:0]) begin
      e.fv = 1'b1;
      e.fp = cp[7:0];
    end
    if (bw) bank = int'(bd[1:0]);
    q.push_back(e);
    tq.push_back(tag);
  endtask

  task automatic sw(input logic [3:0] a, input logic [31:0] d, input string tag);
    step(1, 0, a, d, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic srd(input logic [3:0] a, input string tag);
    step(0, 1, a, 0, 0, 0, 0, 0, 0, tag);
  endtask
  task automatic setbank(input logic [31:0] v, input string tag);
    step(0, 0, 0, 0, 1, v, 0, 0, 0, tag);
  endtask
  task automatic flush(input logic [31:0] p, input logic [31:0] c, input string tag);
    step(0, 0, 0, 0, 0, 0, 1, p, c, tag);
  endtask

  // Monitor: compares outputs a quarter period after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t  e;
        string t;
        bit    bad;
        e = q.pop_front();
        t = tq.pop_front();
        bad = (rd_valid !== e.rv) || (e.rv && rd_data !== e.rd) ||
              (inval_valid !== e.iv) || (e.iv && inval_vaddr !== e.ia) ||
              (pid_flush_o !== e.fv) || (e.fv && pid_flush_id !== e.fp);
        checks++;
        if (bad) begin
          errors++;
          $display("FAIL %s: got rv=%0b rd=%h iv=%0b ia=%h fv=%0b fp=%h exp rv=%0b rd=%h iv=%0b ia=%h fv=%0b fp=%h",
                   t, rd_valid, rd_data, inval_valid, inval_vaddr, pid_flush_o, pid_flush_id,
                   e.rv, e.rd, e.iv, e.ia, e.fv, e.fp);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 4; b++) for (int r = 0; r < 16; r++) bm[b][r] = '0;
    for (int m = 0; m < 2; m++) for (int s = 0; s < 64; s++) begin
      th[m][s] = '0; tl[m][s] = '0; tf[m][s] = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state of outputs
    checks++;
    if (rd_valid !== 1'b0 || rd_data !== '0 || inval_valid !== 1'b0 ||
        inval_vaddr !== '0 || pid_flush_o !== 1'b0 || pid_flush_id !== '0) begin
      errors++;
      $display("FAIL R1: got rv=%0b rd=%h iv=%0b fv=%0b exp all zero",
               rd_valid, rd_data, inval_valid, pid_flush_o);
    end
    setbank(32'h1, "R1");
    srd(4'd6, "R1");
    srd(4'd5, "R1");
    srd(4'd9, "R1");

    // Bank 0: plain storage, no store side effects
    setbank(32'h0, "R3");
    sw(4'd7, 32'h0000_0011, "R3");
    sw(4'd6, 32'h0000_0022, "R4");
    srd(4'd7, "R4");
    sw(4'd4, 32'h0000_0023, "R3");
    sw(4'd5, 32'h0000_0008, "R11");
    sw(4'd5, 32'h0000_0009, "R11");
    srd(4'd5, "R3");
    srd(4'd6, "R3");

    // Bank 1 via upper bits ignored
    setbank(32'hFFFF_FFF5, "R2");
    sw(4'd4, 32'h0000_0023, "R2");
    sw(4'd6, 32'hABCD_F123, "R4");
    srd(4'd7, "R2");
    sw(4'd5, 32'h0000_0008, "R8");
    srd(4'd6, "R5");
    srd(4'd5, "R5");
    sw(4'd6, 32'h5555_5555, "R6");
    srd(4'd6, "R6");
    srd(4'd7, "R4");
    sw(4'd5, 32'h0000_0000, "R8");
    sw(4'd5, 32'h0000_0008, "R8");
    srd(4'd6, "R5");

    // Bank 2 uses the other store
    setbank(32'h2, "R7");
    sw(4'd4, 32'h0000_0023, "R7");
    srd(4'd6, "R7");
    sw(4'd6, 32'h0F0F_2000, "R7");
    sw(4'd5, 32'h0000_000C, "R7");
    srd(4'd5, "R7");
    setbank(32'h1, "R7");
    srd(4'd6, "R7");

    // Back-to-back replacements of a valid slot
    sw(4'd4, 32'h0000_003F, "R5");
    sw(4'd6, 32'hFFFF_FFFF, "R8");
    sw(4'd5, 32'h0000_0008, "R8");
    sw(4'd5, 32'h0000_0008, "R8");
    sw(4'd5, 32'h0000_0008, "R8");
    srd(4'd0, "R6");
    srd(4'd5, "R6");

    // Simultaneous read and write
    step(1, 1, 4'd0, 32'h0000_0077, 0, 0, 0, 0, 0, "R9");
    srd(4'd0, "R9");
    step(1, 1, 4'd5, 32'h0000_0000, 0, 0, 0, 0, 0, "R9");
    srd(4'd6, "R9");

    // Process-ID flush compare
    flush(32'h0000_01FF, 32'h0000_02FF, "R10");
    flush(32'h0000_0012, 32'h0000_0034, "R10");
    flush(32'h0000_0100, 32'h0000_0200, "R10");
    flush(32'h0000_00AB, 32'hFFFF_FF01, "R10");

    // Bank 3: no store side effects
    setbank(32'h3, "R11");
    sw(4'd4, 32'h0000_003F, "R11");
    sw(4'd6, 32'h1234_5678, "R11");
    srd(4'd7, "R11");
    sw(4'd5, 32'h0000_0008, "R11");
    srd(4'd6, "R11");
    setbank(32'h1, "R11");
    sw(4'd4, 32'h0000_003F, "R11");
    srd(4'd5, "R11");

    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
    @(negedge clk);
    sr_wr = 0; sr_rd = 0; bsel_we = 0; pid_flush_req = 0;
    repeat (3) @(posedge clk);
    #6;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule